// File: doc/BRIEF.md
# Program Memory Block Protection Unit

This unit guards a 64 KiB program flash that is reached from two sides: the table read/write port of a CPU and an external programming port. The flash is split into a 2 KiB boot region at the bottom and four equal 16 KiB user regions. The first user region starts just above the boot region, so it is 2 KiB shorter than the other three. For every access the unit works out which region the target address falls in. For CPU reads it also works out which region the executing program counter falls in. It then decides whether the flash may see the access. A refused write never reaches the flash. A refused read returns all zeros. Each refusal raises a violation pulse for one cycle.

Each region has three lock bits: an external-access lock, a table-write lock and a cross-region-read lock. A bit at 1 leaves the region open and a bit at 0 locks it. Software writes to the lock bits can only clear them. Only erase commands from the programming port can set them again. The programming port has priority over the CPU port for the flash. Addresses at or above 0x010000 (configuration and ID space) are not checked.

Top module: `pmem_guard`

## Requirements
- R1: Region decode. 0x000000..0x0007FF is the boot region with lock bit index 4. For k = 0..3, user region k is the address range whose bits [15:14] equal k, minus the boot range. So region 0 runs from 0x000800 to 0x003FFF and region 3 from 0x00C000 to 0x00FFFF.
- R2: A CPU table write to a region whose table-write lock bit (`wrt_o`) is 0 does not assert `fl_wr_en`. Writes to open regions do assert it in the same cycle.
- R3: When a region's cross-region-read lock bit (`ebtr_o`) is 0, a CPU table read of that region is allowed only when `tbl_pc` lies in the same region. Otherwise `tbl_rdata` is 0 in the following cycle. When the bit is 1, reads are always allowed.
- R4: The external-access lock bits (`cp_o`) have no effect on the CPU port. A programming-port access to a region whose bit is 0 asserts neither flash enable, and its `prg_rdata` is 0.
- R5: A lock write (`lk_we`) updates only the set chosen by `lk_sel` (0 = external, 1 = table-write, 2 = cross-read, 3 = none). The new value is old AND `lk_wdata`, with bit i belonging to user region i and bit 4 to the boot region. A 0 can never be written back to 1.
- R6: `prg_erase_chip` sets all lock bits of all three sets to 1. `prg_erase_blk` with `prg_erase_idx` = i (0..4, same numbering as R5) sets only bit i of each set. Erase indices 5..7 have no effect.
- R7: Addresses at or above 0x010000 are allowed on both ports whatever the lock bits hold.
- R8: `viol` is high in the cycle after each refused access, for one cycle per refusal. It is low otherwise.
- R9: After reset every lock bit is 1, and `viol`, `tbl_rdata` and `prg_rdata` are 0.
- R10: When `prg_req` and `tbl_req` are both high, the flash carries the programming-port access. The CPU access is dropped without a violation, and its `tbl_rdata` is 0.
- R11: An erase in the same cycle as a lock write wins, and the lock write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_req | input | 1 | CPU table access request |
| tbl_we | input | 1 | CPU access is a write |
| tbl_addr | input | 22 | CPU table pointer |
| tbl_pc | input | 22 | Program counter of the executing table instruction |
| tbl_wdata | input | 8 | CPU write data |
| tbl_rdata | output | 8 | CPU read data, zero when refused |
| prg_req | input | 1 | Programming-port access request |
| prg_we | input | 1 | Programming-port access is a write |
| prg_addr | input | 22 | Programming-port address |
| prg_wdata | input | 8 | Programming-port write data |
| prg_rdata | output | 8 | Programming-port read data, zero when refused |
| lk_we | input | 1 | Lock bit write strobe |
| lk_sel | input | 2 | Lock set select |
| lk_wdata | input | 5 | Lock write value (ANDed in) |
| prg_erase_chip | input | 1 | Full erase, sets all lock bits |
| prg_erase_blk | input | 1 | Region erase, sets one region's lock bits |
| prg_erase_idx | input | 3 | Region index for region erase |
| cp_o | output | 5 | External-access lock bits |
| wrt_o | output | 5 | Table-write lock bits |
| ebtr_o | output | 5 | Cross-region-read lock bits |
| fl_rd_en | output | 1 | Flash read enable |
| fl_wr_en | output | 1 | Flash write enable |
| fl_addr | output | 22 | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, one cycle after `fl_rd_en` |
| viol | output | 1 | One-cycle refusal pulse |

## Verification
Flash enables are combinational, so the bench samples them 1 ns after it drives a request, in the same cycle. Lock-bit outputs change at the edge that takes a lock write or an erase, and the bench samples them at the next falling edge. `viol` and gated read data come out of one register stage, with the flash model's registered read lined up to it. The bench samples both at the falling edge one cycle after the request. It then checks `viol` once more a cycle later to confirm that the pulse has ended.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;

   // Lock set selector carried on lk_sel
   typedef enum logic [1:0] {
      LSEL_EXT  = 2'd0,
      LSEL_WR   = 2'd1,
      LSEL_XRD  = 2'd2,
      LSEL_NONE = 2'd3
   } lock_sel_e;

   localparam int LOCK_SETS = 3;

endpackage

// File: rtl/pmem_guard_region.sv
// Address-to-region decoder: one-hot hit vector, boot region at index USER_BLOCKS.
module pmem_guard_region #(
   parameter int ADDR_W      = 22,
   parameter int FLASH_AW    = 16,
   parameter int BOOT_AW     = 11,
   parameter int USER_BLOCKS = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [USER_BLOCKS:0] hit
);
   localparam int SEL_W   = $clog2(USER_BLOCKS);
   localparam int USER_AW = FLASH_AW - SEL_W;

   logic in_flash;
   logic in_boot;

   if (USER_BLOCKS < 2 || (1 << SEL_W) != USER_BLOCKS) begin : g_bad_blocks
      $error("USER_BLOCKS must be a power of two of at least 2");
   end
   if (BOOT_AW >= USER_AW) begin : g_bad_boot
      $error("boot region must be smaller than one user region");
   end
   if (ADDR_W < FLASH_AW) begin : g_bad_aw
      $error("ADDR_W must cover the flash");
   end

   if (ADDR_W > FLASH_AW) begin : g_hi
      assign in_flash = ~|addr[ADDR_W-1:FLASH_AW];
   end else begin : g_nohi
      assign in_flash = 1'b1;
   end

   assign in_boot = in_flash & ~|addr[FLASH_AW-1:BOOT_AW];

   for (genvar i = 0; i < USER_BLOCKS; i++) begin : g_user
      assign hit[i] = in_flash & ~in_boot &
                      (addr[FLASH_AW-1:USER_AW] == SEL_W'(i));
   end
   assign hit[USER_BLOCKS] = in_boot;

   logic unused_low;
   assign unused_low = ^addr[BOOT_AW-1:0];

endmodule

// File: rtl/pmem_guard_lockbits.sv
// Lock bit store: clear-only writes, set only by erase.
module pmem_guard_lockbits
   import pmem_guard_pkg::*;
#(
   parameter int NB    = 5,
   parameter int IDX_W = $clog2(NB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NB-1:0]    wr_data,
   input  logic             era_chip,
   input  logic             era_blk,
   input  logic [IDX_W-1:0] era_idx,
   output logic [NB-1:0]    cp_o,
   output logic [NB-1:0]    wrt_o,
   output logic [NB-1:0]    ebtr_o
);
   logic [NB-1:0] bits_q [LOCK_SETS];
   logic [NB-1:0] era_mask;
   logic          era_req;

   assign era_req = era_chip | era_blk;

   always_comb begin
      era_mask = '0;
      if (era_chip) begin
         era_mask = '1;
      end else if (era_blk && int'(era_idx) < NB) begin
         era_mask[era_idx] = 1'b1;
      end
   end

   for (genvar k = 0; k < LOCK_SETS; k++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits_q[k] <= '1;
         end else if (era_req) begin
            bits_q[k] <= bits_q[k] | era_mask;
         end else if (wr_en && wr_sel == 2'(k)) begin
            bits_q[k] <= bits_q[k] & wr_data;
         end
      end

      // a bit may rise only after an erase
      assert_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !era_req |=> ((bits_q[k] & ~$past(bits_q[k])) == '0));

      // lock write ANDs the data in when no erase competes
      assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == 2'(k) && !era_req)
            |=> (bits_q[k] == ($past(bits_q[k]) & $past(wr_data))));

      assert_chip_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
         era_chip |=> (bits_q[k] == '1));

      assert_blk_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (era_blk && !era_chip && int'(era_idx) < NB) |=> bits_q[k][$past(era_idx)]);

      // erase beats a simultaneous write
      assert_erase_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (era_req && wr_en) |=> ((bits_q[k] & $past(bits_q[k])) == $past(bits_q[k])));
   end

   assign cp_o   = bits_q[int'(LSEL_EXT)];
   assign wrt_o  = bits_q[int'(LSEL_WR)];
   assign ebtr_o = bits_q[int'(LSEL_XRD)];

endmodule

// File: rtl/pmem_guard_judge.sv
// Access decision; variant chosen by port kind.
module pmem_guard_judge #(
   parameter int NB       = 5,
   parameter bit EXT_PORT = 1'b0
) (
   input  logic [NB-1:0] tgt_hit,
   input  logic [NB-1:0] pc_hit,
   input  logic [NB-1:0] cp,
   input  logic [NB-1:0] wrt,
   input  logic [NB-1:0] ebtr,
   input  logic          we,
   output logic          allow
);
   if (EXT_PORT) begin : g_ext
      assign allow = ~|(tgt_hit & ~cp);
      logic unused_ext;
      assign unused_ext = ^{pc_hit, wrt, ebtr, we};
   end else begin : g_cpu
      assign allow = we ? ~|(tgt_hit & ~wrt)
                        : ~|(tgt_hit & ~ebtr & ~pc_hit);
      logic unused_cpu;
      assign unused_cpu = ^cp;
   end

endmodule

// File: rtl/pmem_guard.sv
// Program flash region protection between CPU table port, programming port and flash.
module pmem_guard #(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 8,
   parameter int FLASH_AW    = 16,
   parameter int BOOT_AW     = 11,
   parameter int USER_BLOCKS = 4,
   localparam int NB         = USER_BLOCKS + 1,
   localparam int IDX_W      = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_req,
   input  logic              tbl_we,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [ADDR_W-1:0] tbl_pc,
   input  logic [DATA_W-1:0] tbl_wdata,
   output logic [DATA_W-1:0] tbl_rdata,
   input  logic              prg_req,
   input  logic              prg_we,
   input  logic [ADDR_W-1:0] prg_addr,
   input  logic [DATA_W-1:0] prg_wdata,
   output logic [DATA_W-1:0] prg_rdata,
   input  logic              lk_we,
   input  logic [1:0]        lk_sel,
   input  logic [NB-1:0]     lk_wdata,
   input  logic              prg_erase_chip,
   input  logic              prg_erase_blk,
   input  logic [IDX_W-1:0]  prg_erase_idx,
   output logic [NB-1:0]     cp_o,
   output logic [NB-1:0]     wrt_o,
   output logic [NB-1:0]     ebtr_o,
   output logic              fl_rd_en,
   output logic              fl_wr_en,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   input  logic [DATA_W-1:0] fl_rdata,
   output logic              viol
);
   logic [NB-1:0] cpu_tgt_hit, cpu_pc_hit, ext_tgt_hit;
   logic          cpu_ok, ext_ok, cpu_go;
   logic          cpu_rd_q, ext_rd_q, viol_q;
   logic          refuse;

   pmem_guard_region #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .BOOT_AW(BOOT_AW),
                       .USER_BLOCKS(USER_BLOCKS))
      u_cpu_tgt (.addr(tbl_addr), .hit(cpu_tgt_hit));
   pmem_guard_region #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .BOOT_AW(BOOT_AW),
                       .USER_BLOCKS(USER_BLOCKS))
      u_cpu_pc  (.addr(tbl_pc), .hit(cpu_pc_hit));
   pmem_guard_region #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .BOOT_AW(BOOT_AW),
                       .USER_BLOCKS(USER_BLOCKS))
      u_ext_tgt (.addr(prg_addr), .hit(ext_tgt_hit));

   pmem_guard_lockbits #(.NB(NB), .IDX_W(IDX_W)) u_locks (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lk_we),
      .wr_sel   (lk_sel),
      .wr_data  (lk_wdata),
      .era_chip (prg_erase_chip),
      .era_blk  (prg_erase_blk),
      .era_idx  (prg_erase_idx),
      .cp_o     (cp_o),
      .wrt_o    (wrt_o),
      .ebtr_o   (ebtr_o)
   );

   pmem_guard_judge #(.NB(NB), .EXT_PORT(1'b0)) u_cpu_judge (
      .tgt_hit(cpu_tgt_hit), .pc_hit(cpu_pc_hit), .cp(cp_o), .wrt(wrt_o),
      .ebtr(ebtr_o), .we(tbl_we), .allow(cpu_ok));
   pmem_guard_judge #(.NB(NB), .EXT_PORT(1'b1)) u_ext_judge (
      .tgt_hit(ext_tgt_hit), .pc_hit(cpu_pc_hit), .cp(cp_o), .wrt(wrt_o),
      .ebtr(ebtr_o), .we(prg_we), .allow(ext_ok));

   // programming port owns the flash whenever it requests
   assign cpu_go   = tbl_req & ~prg_req;
   assign fl_addr  = prg_req ? prg_addr  : tbl_addr;
   assign fl_wdata = prg_req ? prg_wdata : tbl_wdata;
   assign fl_wr_en = prg_req ? (prg_we & ext_ok)  : (cpu_go & tbl_we & cpu_ok);
   assign fl_rd_en = prg_req ? (~prg_we & ext_ok) : (cpu_go & ~tbl_we & cpu_ok);
   assign refuse   = (cpu_go & ~cpu_ok) | (prg_req & ~ext_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rd_q <= 1'b0;
         ext_rd_q <= 1'b0;
         viol_q   <= 1'b0;
      end else begin
         cpu_rd_q <= cpu_go & ~tbl_we & cpu_ok;
         ext_rd_q <= prg_req & ~prg_we & ext_ok;
         viol_q   <= refuse;
      end
   end

   assign tbl_rdata = cpu_rd_q ? fl_rdata : '0;
   assign prg_rdata = ext_rd_q ? fl_rdata : '0;
   assign viol      = viol_q;

   assert_wr_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_go && tbl_we && |(cpu_tgt_hit & ~wrt_o)) |-> !fl_wr_en);

   assert_xrd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_go && !tbl_we && |(cpu_tgt_hit & ~ebtr_o & ~cpu_pc_hit)) |=> (tbl_rdata == '0));

   assert_ext_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_req && |(ext_tgt_hit & ~cp_o)) |-> (!fl_wr_en && !fl_rd_en));

   assert_hi_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_go && cpu_tgt_hit == '0) |-> (fl_wr_en || fl_rd_en));

   assert_viol_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> viol);

   assert_viol_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !refuse |=> !viol);

   assert_ext_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_req && tbl_req) |=> (tbl_rdata == '0));

endmodule

// File: tb/pmem_guard_tb_top.sv
module pmem_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_req = 0, tbl_we = 0;
   logic [21:0] tbl_addr = '0, tbl_pc = '0;
   logic [7:0]  tbl_wdata = '0;
   logic [7:0]  tbl_rdata;
   logic        prg_req = 0, prg_we = 0;
   logic [21:0] prg_addr = '0;
   logic [7:0]  prg_wdata = '0;
   logic [7:0]  prg_rdata;
   logic        lk_we = 0;
   logic [1:0]  lk_sel = 2'd3;
   logic [4:0]  lk_wdata = '1;
   logic        prg_erase_chip = 0, prg_erase_blk = 0;
   logic [2:0]  prg_erase_idx = '0;
   logic [4:0]  cp_o, wrt_o, ebtr_o;
   logic        fl_rd_en, fl_wr_en;
   logic [21:0] fl_addr;
   logic [7:0]  fl_wdata;
   logic [7:0]  fl_rdata = '0;
   logic        viol;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [4:0] e_cp = '1, e_wrt = '1, e_xrd = '1;
   logic [7:0] fmem [int];

   always #4 clk = ~clk;

   pmem_guard dut_i (.*);

   function automatic logic [7:0] fm_rd(input logic [21:0] a);
      if (fmem.exists(int'(a))) return fmem[int'(a)];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // flash stand-in: registered read
   always @(posedge clk) begin
      if (fl_wr_en) fmem[int'(fl_addr)] = fl_wdata;
      if (fl_rd_en) fl_rdata <= fm_rd(fl_addr);
   end

   // region numbering of R1: 0..3 user, 4 boot, 5 outside
   function automatic int reg_of(input logic [21:0] a);
      if (a >= 22'h010000) return 5;
      if (a < 22'h000800) return 4;
      return int'(a[15:14]);
   endfunction

   function automatic bit cpu_allow(input bit we, input logic [21:0] a, input logic [21:0] pc);
      int r = reg_of(a);
      if (r == 5) return 1'b1;
      if (we) return e_wrt[r];
      return e_xrd[r] || reg_of(pc) == r;
   endfunction

   function automatic bit ext_allow(input logic [21:0] a);
      int r = reg_of(a);
      if (r == 5) return 1'b1;
      return e_cp[r];
   endfunction

   function automatic logic [21:0] pick(input int r);
      case (r)
         0: return 22'($urandom % 32'h800);
         1: return 22'(32'h800 + $urandom % 32'h3800);
         2, 3, 4: return 22'((r - 1) << 14) | 22'($urandom % 32'h4000);
         default: return 22'h300000 | 22'($urandom % 16);
      endcase
   endfunction

   task automatic chk(input bit good, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic chk_locks(input string rq);
      chk(cp_o == e_cp, rq, "external lock bits", cp_o, e_cp);
      chk(wrt_o == e_wrt, rq, "write lock bits", wrt_o, e_wrt);
      chk(ebtr_o == e_xrd, rq, "cross-read lock bits", ebtr_o, e_xrd);
   endtask

   task automatic cpu_op(input bit we, input logic [21:0] a, input logic [21:0] pc,
                         input logic [7:0] d, input string rq);
      bit ok;
      logic [7:0] ed;
      @(negedge clk);
      tbl_req = 1; tbl_we = we; tbl_addr = a; tbl_pc = pc; tbl_wdata = d;
      #1;
      ok = cpu_allow(we, a, pc);
      ed = (ok && !we) ? fm_rd(a) : 8'h00;
      chk(fl_wr_en == (we && ok), rq, "cpu flash write enable", fl_wr_en, we && ok);
      chk(fl_rd_en == (!we && ok), rq, "cpu flash read enable", fl_rd_en, !we && ok);
      @(negedge clk);
      tbl_req = 0;
      chk(viol == !ok, "R8", "violation after cpu access", viol, !ok);
      if (!we) chk(tbl_rdata == ed, rq, "cpu read data", tbl_rdata, ed);
      @(negedge clk);
      chk(viol == 1'b0, "R8", "violation pulse length", viol, 0);
   endtask

   task automatic ext_op(input bit we, input logic [21:0] a, input logic [7:0] d,
                         input string rq);
      bit ok;
      logic [7:0] ed;
      @(negedge clk);
      prg_req = 1; prg_we = we; prg_addr = a; prg_wdata = d;
      #1;
      ok = ext_allow(a);
      ed = (ok && !we) ? fm_rd(a) : 8'h00;
      chk(fl_wr_en == (we && ok), rq, "ext flash write enable", fl_wr_en, we && ok);
      chk(fl_rd_en == (!we && ok), rq, "ext flash read enable", fl_rd_en, !we && ok);
      @(negedge clk);
      prg_req = 0;
      chk(viol == !ok, "R8", "violation after ext access", viol, !ok);
      if (!we) chk(prg_rdata == ed, rq, "ext read data", prg_rdata, ed);
      @(negedge clk);
   endtask

   task automatic lock_wr(input logic [1:0] sel, input logic [4:0] d);
      @(negedge clk);
      lk_we = 1; lk_sel = sel; lk_wdata = d;
      @(negedge clk);
      lk_we = 0; lk_sel = 2'd3; lk_wdata = '1;
      case (sel)
         2'd0: e_cp &= d;
         2'd1: e_wrt &= d;
         2'd2: e_xrd &= d;
         default: ;
      endcase
      chk_locks("R5");
   endtask

   task automatic erase(input bit chip, input logic [2:0] idx, input bit with_wr);
      logic [4:0] m;
      @(negedge clk);
      prg_erase_chip = chip; prg_erase_blk = !chip; prg_erase_idx = idx;
      if (with_wr) begin lk_we = 1; lk_sel = 2'd1; lk_wdata = '0; end
      @(negedge clk);
      prg_erase_chip = 0; prg_erase_blk = 0; lk_we = 0; lk_sel = 2'd3; lk_wdata = '1;
      m = chip ? 5'h1F : (idx < 5 ? 5'(1 << idx) : 5'h00);
      e_cp |= m; e_wrt |= m; e_xrd |= m;
      chk_locks(with_wr ? "R11" : "R6");
   endtask

   initial begin
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      chk_locks("R9");
      chk(viol == 0, "R9", "viol after reset", viol, 0);
      chk(tbl_rdata == 0, "R9", "tbl_rdata after reset", tbl_rdata, 0);
      chk(prg_rdata == 0, "R9", "prg_rdata after reset", prg_rdata, 0);

      // open regions, write then cross-region read
      cpu_op(1, 22'h004123, 22'h000100, 8'hA5, "R2");
      cpu_op(0, 22'h004123, 22'h00C000, 8'h00, "R3");

      // R1 edges with region 0 write-locked
      lock_wr(2'd1, 5'b11110);
      cpu_op(1, 22'h0007FF, 22'h000010, 8'h11, "R1");
      cpu_op(1, 22'h000800, 22'h000010, 8'h22, "R1");
      cpu_op(1, 22'h003FFF, 22'h000010, 8'h33, "R1");
      cpu_op(1, 22'h004000, 22'h000010, 8'h44, "R1");
      lock_wr(2'd1, 5'b11111);  // R5: cannot re-open

      // R3 cross-region read lock on region 2
      lock_wr(2'd2, 5'b11011);
      cpu_op(0, 22'h008010, 22'h008F00, 8'h00, "R3");
      cpu_op(0, 22'h008010, 22'h003FFE, 8'h00, "R3");
      cpu_op(0, 22'h008010, 22'h020000, 8'h00, "R3");
      cpu_op(0, 22'h00BFFF, 22'h008000, 8'h00, "R3");

      // R4 external lock on region 1
      lock_wr(2'd0, 5'b11101);
      cpu_op(0, 22'h004123, 22'h000200, 8'h00, "R4");
      cpu_op(1, 22'h004124, 22'h000200, 8'h66, "R4");
      ext_op(0, 22'h004123, 8'h00, "R4");
      ext_op(1, 22'h004123, 8'hEE, "R4");
      ext_op(0, 22'h000100, 8'h00, "R4");

      // R6 region erase then full erase
      erase(0, 3'd1, 0);
      erase(0, 3'd6, 0);
      erase(1, 3'd0, 0);

      // R7 everything locked, outside space still open
      lock_wr(2'd0, 5'b00000);
      lock_wr(2'd1, 5'b00000);
      lock_wr(2'd2, 5'b00000);
      cpu_op(1, 22'h300005, 22'h004000, 8'h5C, "R7");
      cpu_op(0, 22'h300005, 22'h004000, 8'h00, "R7");
      ext_op(0, 22'h300005, 8'h00, "R7");
      cpu_op(0, 22'h00FFFF, 22'h00C123, 8'h00, "R3");
      cpu_op(0, 22'h0007FF, 22'h000800, 8'h00, "R3");

      // R11 erase against simultaneous write
      erase(0, 3'd0, 1);

      // R10 both ports at once
      @(negedge clk);
      tbl_req = 1; tbl_we = 0; tbl_addr = 22'h000010; tbl_pc = 22'h000010;
      prg_req = 1; prg_we = 0; prg_addr = 22'h300001;
      #1;
      chk(fl_addr == 22'h300001, "R10", "flash address owner", fl_addr, 22'h300001);
      chk(fl_rd_en == 1'b1, "R10", "flash read by ext", fl_rd_en, 1);
      @(negedge clk);
      tbl_req = 0; prg_req = 0;
      chk(tbl_rdata == 8'h00, "R10", "dropped cpu data", tbl_rdata, 0);
      chk(prg_rdata == fm_rd(22'h300001), "R10", "ext data", prg_rdata, fm_rd(22'h300001));
      chk(viol == 0, "R10", "no violation for dropped cpu access", viol, 0);
      erase(1, 3'd0, 0);

      // constrained random mix
      for (int it = 0; it < 800; it++) begin
         int c = int'($urandom % 20);
         if (c == 0) begin
            lock_wr(2'($urandom % 3), 5'($urandom));
         end else if (c == 1) begin
            if ($urandom % 3 == 0) erase(1, 3'd0, 0);
            else erase(0, 3'($urandom % 5), 0);
         end else if (c < 13) begin
            bit we = 1'($urandom);
            logic [21:0] a = pick(int'($urandom % 6));
            logic [21:0] pc = pick(int'($urandom % 6));
            cpu_op(we, a, pc, 8'($urandom), reg_of(a) == 5 ? "R7" : (we ? "R2" : "R3"));
         end else begin
            logic [21:0] a = pick(int'($urandom % 6));
            ext_op(1'($urandom), a, 8'($urandom), reg_of(a) == 5 ? "R7" : "R4");
         end
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule